// File: doc/BRIEF.md
# Stuck Bus Recovery Controller

This block sits beside a two-wire bus buffer and watches the two lines on the buffer's outward-facing side: the data line and the clock line. Each line has its own low-time counter. When either line has been low for a full timeout, the block raises a fault flag that tells the buffer to separate its two sides. If enable is high, it then runs a recovery sequence on the outward bus. The sequence is a guard pause, a burst of clock pulses capped at a set count, and a stop condition.

The burst ends early once both lines read high at the end of a clock high half. The stop condition is sent in every case, even when no pulse was needed. After the sequence, the fault flag stays set while the bus is still stuck. It clears only when enable is high and the bus shows a stop condition or a run of idle time. A rising edge on enable clears the flag at once and restarts both counters, and the counters keep running afterwards.

All times are counted in tick pulses from a shared time reference; the parameters are tick counts. Line levels arrive already sampled and synchronous. The pull outputs are open-drain requests: a 1 means pull the line low. There is no data stream, so every pin is a plain level with no handshake.

Top module: `stuck_bus_recovery`

## Requirements
- R1: Each line has its own low-time counter. A counter advances on each tick while its line is low and returns to zero whenever its line reads high. Low spells shorter than TIMEOUT ticks on either line, including spells that alternate between the lines, never raise the fault.
- R2: When a line has been low for TIMEOUT consecutive ticks, fault_disc rises at the next clock edge. With tick held high, a line that first reads low at edge 1 gives fault_disc high after edge TIMEOUT+1.
- R3: When the fault rises with enable high, recov_active is high. scl_pull first asserts exactly GUARD ticks after fault_disc rises. Each pulse then holds scl_pull high for HALF ticks and low for HALF ticks.
- R4: A pulse is one assertion of scl_pull while sda_pull is low. At most NPULSE pulses are issued. The burst ends after the pulse at whose high-half end both lines read high, and it ends with zero pulses if both lines are high when the guard ends.
- R5: Every sequence ends with a stop condition, including one with zero pulses. First both pulls are asserted for HALF ticks. Then scl_pull is released while sda_pull is held for HALF ticks. Then sda_pull is released with scl_pull low.
- R6: After the sequence, fault_disc stays high while the bus is stuck. With enable high and no sequence running, it clears one edge after a stop is seen (the data line rising while the clock line reads high on both samples), or one edge after both lines have read high for IDLE ticks.
- R7: A rising edge on en clears fault_disc at that edge, even if a line is still low. It also restarts both counters, so a line that stays low raises the fault again TIMEOUT+1 edges later.
- R8: While en is low, no pull is asserted and no sequence starts, but a timeout still sets fault_disc. If en falls during a sequence, both pulls and recov_active drop at the next edge and fault_disc stays high.
- R9: During reset and after it, all outputs are low. A line that is already low when reset is released raises the fault TIMEOUT+1 edges later, and recovery follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on lockout) |
| tick | input | 1 | Time-base pulse that advances all counters |
| en | input | 1 | Enable level; a rising edge forces reconnection |
| sda_lvl | input | 1 | Sampled level of the outward data line |
| scl_lvl | input | 1 | Sampled level of the outward clock line |
| scl_pull | output | 1 | Request to pull the outward clock line low |
| sda_pull | output | 1 | Request to pull the outward data line low |
| fault_disc | output | 1 | Sides are separated because of a stuck-low fault |
| recov_active | output | 1 | Recovery sequence in progress |

## Verification
Two events can land on the same clock edge: the end of the burst because the pulse cap is reached, and the end of the burst because the bus has been freed. The bench provokes this by releasing the stuck line in the high half of exactly the NPULSE-th pulse. It expects exactly NPULSE pulses, one stop condition, and a single reconnection, with no extra pulse and no second stop. Random runs pick the stuck line and the release pulse (zero, inside the cap, at the cap, or never) under gated ticks. Each run is judged against the expected pulse count, which is the smaller of the release index and the cap.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_GUARD,
    RS_CLK_LO,
    RS_CLK_HI,
    RS_STOP_LO,
    RS_STOP_HI
  } rec_state_t;

  localparam int unsigned LINE_SDA  = 0;
  localparam int unsigned LINE_SCL  = 1;
  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/sbr_low_timer.sv
module sbr_low_timer #(
  parameter int unsigned LIMIT = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic line_i,
  input  logic clr_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr_i || line_i)   cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIM);

  // R1: a high line restarts its counter
  assert_line_high_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_i |=> (cnt_q == '0));

  // R1: counter never passes its limit
  assert_timer_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
endmodule

// File: rtl/sbr_recovery_seq.sv
module sbr_recovery_seq
  import sbr_pkg::*;
#(
  parameter int unsigned GUARD  = 40,
  parameter int unsigned HALF   = 59,
  parameter int unsigned NPULSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic en_i,
  input  logic start_i,
  input  logic bus_free_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o
);
  localparam int unsigned PH_MAX = (GUARD > HALF) ? GUARD : HALF;
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam int unsigned PC_W   = $clog2(NPULSE + 1);
  localparam logic [PH_W-1:0] GUARD_END = PH_W'(GUARD - 1);
  localparam logic [PH_W-1:0] HALF_END  = PH_W'(HALF - 1);
  localparam logic [PC_W-1:0] PC_MAX    = PC_W'(NPULSE);

  rec_state_t      st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PH_W-1:0] ph_end;
  logic            phase_end;

  assign ph_end    = (st_q == RS_GUARD) ? GUARD_END : HALF_END;
  assign phase_end = tick_i && (ph_q == ph_end);

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    pc_d = pc_q;
    if (st_q != RS_IDLE && tick_i && !phase_end) ph_d = ph_q + 1'b1;
    unique case (st_q)
      RS_IDLE: begin
        if (start_i && en_i) begin
          st_d = RS_GUARD;
          ph_d = '0;
          pc_d = '0;
        end
      end
      RS_GUARD: begin
        if (phase_end) begin
          st_d = bus_free_i ? RS_STOP_LO : RS_CLK_LO;
          ph_d = '0;
        end
      end
      RS_CLK_LO: begin
        if (phase_end) begin
          st_d = RS_CLK_HI;
          ph_d = '0;
          pc_d = pc_q + 1'b1;
        end
      end
      RS_CLK_HI: begin
        if (phase_end) begin
          st_d = (bus_free_i || pc_q == PC_MAX) ? RS_STOP_LO : RS_CLK_LO;
          ph_d = '0;
        end
      end
      RS_STOP_LO: begin
        if (phase_end) begin
          st_d = RS_STOP_HI;
          ph_d = '0;
        end
      end
      RS_STOP_HI: begin
        if (phase_end) begin
          st_d = RS_IDLE;
          ph_d = '0;
        end
      end
      default: st_d = RS_IDLE;
    endcase
    if (!en_i) begin
      st_d = RS_IDLE;
      ph_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= RS_IDLE;
      ph_q <= '0;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      pc_q <= pc_d;
    end
  end

  assign scl_pull_o = (st_q == RS_CLK_LO) || (st_q == RS_STOP_LO);
  assign sda_pull_o = (st_q == RS_STOP_LO) || (st_q == RS_STOP_HI);
  assign busy_o     = (st_q != RS_IDLE);

  // R8: a low enable silences both pulls from the next edge
  assert_quiet_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!scl_pull_o && !sda_pull_o));

  // R4: the pulse count never exceeds the cap
  assert_pulse_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= PC_MAX);

  // R5: data is released only while the clock line is released
  assert_stop_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull_o) && $past(en_i)) |-> (!scl_pull_o && !$past(scl_pull_o)));

  // R3: clock pulling starts only after the guard or a high half
  assert_pull_after_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_o) |-> ($past(st_q == RS_GUARD) || $past(st_q == RS_CLK_HI)));
endmodule

// File: rtl/sbr_reconnect.sv
module sbr_reconnect #(
  parameter int unsigned IDLE = 95
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic en_i,
  input  logic en_rise_i,
  input  logic set_i,
  input  logic seq_idle_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic fault_o
);
  localparam int unsigned IW = $clog2(IDLE + 1);
  localparam logic [IW-1:0] ILIM = IW'(IDLE);

  logic          sda_q, scl_q, fault_q;
  logic [IW-1:0] icnt_q;
  logic          stop_det, idle_full, clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        icnt_q <= '0;
    else if (!(sda_i && scl_i))        icnt_q <= '0;
    else if (tick_i && icnt_q != ILIM) icnt_q <= icnt_q + 1'b1;
  end

  assign stop_det  = sda_i && !sda_q && scl_i && scl_q;
  assign idle_full = (icnt_q == ILIM);
  assign clear     = fault_q && seq_idle_i && en_i && (stop_det || idle_full);

  always_ff @(posedge clk) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (en_rise_i) fault_q <= 1'b0;
    else if (set_i)     fault_q <= 1'b1;
    else if (clear)     fault_q <= 1'b0;
  end

  assign fault_o = fault_q;

  // R7: enable rising edge reconnects at once
  assert_enrise_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise_i |=> !fault_o);

  // R2: a timeout sets the fault flag at the next edge
  assert_timeout_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !en_rise_i) |=> fault_o);

  // R6: a data line still low keeps the sides apart
  assert_hold_while_stuck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !en_rise_i && !sda_i) |=> fault_o);
endmodule

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery
  import sbr_pkg::*;
#(
  parameter int unsigned TIMEOUT = 30000,
  parameter int unsigned GUARD   = 40,
  parameter int unsigned HALF    = 59,
  parameter int unsigned NPULSE  = 16,
  parameter int unsigned IDLE    = 95
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic sda_lvl,
  input  logic scl_lvl,
  output logic scl_pull,
  output logic sda_pull,
  output logic fault_disc,
  output logic recov_active
);
  logic [NUM_LINES-1:0] line_lvl;
  logic [NUM_LINES-1:0] expired;
  logic en_q, en_rise, busy, trigger, timer_clr;

  assign line_lvl[LINE_SDA] = sda_lvl;
  assign line_lvl[LINE_SCL] = scl_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en;
  end

  assign en_rise   = en && !en_q;
  assign timer_clr = busy || en_rise;
  assign trigger   = (|expired) && !fault_disc && !en_rise;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line_timer
    sbr_low_timer #(.LIMIT(TIMEOUT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .line_i   (line_lvl[g]),
      .clr_i    (timer_clr),
      .expired_o(expired[g])
    );
  end

  sbr_recovery_seq #(.GUARD(GUARD), .HALF(HALF), .NPULSE(NPULSE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .en_i      (en),
    .start_i   (trigger),
    .bus_free_i(sda_lvl && scl_lvl),
    .scl_pull_o(scl_pull),
    .sda_pull_o(sda_pull),
    .busy_o    (busy)
  );

  sbr_reconnect #(.IDLE(IDLE)) u_reconnect (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .en_i      (en),
    .en_rise_i (en_rise),
    .set_i     (trigger),
    .seq_idle_i(!busy),
    .sda_i     (sda_lvl),
    .scl_i     (scl_lvl),
    .fault_o   (fault_disc)
  );

  assign recov_active = busy;

  // R2: recovery runs only while the fault flag is up
  assert_seq_within_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> fault_disc);

  // R8: with enable low no sequence is launched
  assert_no_start_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> !busy);
endmodule

// File: tb/stuck_bus_recovery_bench.sv
module stuck_bus_recovery_bench;
  localparam int TO = 40;
  localparam int GD = 6;
  localparam int HF = 4;
  localparam int NP = 16;
  localparam int ID = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic en = 1'b1;
  logic sda_dev = 1'b0;
  logic scl_dev = 1'b0;
  logic sda_lvl, scl_lvl;
  logic scl_pull, sda_pull, fault_disc, recov_active;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit rnd_tick = 1'b0;

  assign sda_lvl = !(sda_pull || sda_dev);
  assign scl_lvl = !(scl_pull || scl_dev);

  always #10 clk = !clk;

  stuck_bus_recovery #(.TIMEOUT(TO), .GUARD(GD), .HALF(HF), .NPULSE(NP), .IDLE(ID))
    u_stuck_bus_recovery (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
      .sda_lvl(sda_lvl), .scl_lvl(scl_lvl),
      .scl_pull(scl_pull), .sda_pull(sda_pull),
      .fault_disc(fault_disc), .recov_active(recov_active));

  function automatic int exp_pulses(input int k);
    return (k > NP) ? NP : k;
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    tick = rnd_tick ? (($urandom % 4) != 0) : 1'b1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic release_line(input bit on_scl);
    if (on_scl) scl_dev = 1'b0;
    else        sda_dev = 1'b0;
  endtask

  task automatic wait_fault(input bit val, input int max);
    for (int i = 0; i < max; i++) begin
      if (fault_disc == val) break;
      step();
    end
  endtask

  task automatic wait_active(input int max);
    for (int i = 0; i < max; i++) begin
      if (recov_active) break;
      step();
    end
  endtask

  // Follows one sequence; k is the pulse in whose high half the device lets go.
  task automatic watch(input int k, input bit on_scl, output int pulses, output int stops,
                       output int gap, output int lo_len, output int hi_len);
    int idx = 0;
    int hold = 0;
    int rise1 = -1;
    int fall1 = -1;
    int rise2 = -1;
    bit pscl = 1'b0;
    bit psda = 1'b0;
    bit rel = 1'b0;
    pulses = 0;
    stops = 0;
    if (k == 0) begin
      release_line(on_scl);
      rel = 1'b1;
    end
    for (int it = 0; it < 4000; it++) begin
      step();
      idx++;
      if (scl_pull && !pscl && !sda_pull) begin
        pulses++;
        if (rise1 < 0) rise1 = idx;
        else if (rise2 < 0) rise2 = idx;
      end
      if (!scl_pull && pscl && !sda_pull) begin
        if (fall1 < 0) fall1 = idx;
        if (!rel && pulses == k) begin
          release_line(on_scl);
          rel = 1'b1;
        end
      end
      if (psda && !sda_pull && !scl_pull && !pscl && hold >= HF) stops++;
      hold = (!scl_pull && sda_pull) ? hold + 1 : 0;
      pscl = scl_pull;
      psda = sda_pull;
      if (!recov_active) break;
    end
    gap = rise1;
    lo_len = fall1 - rise1;
    hi_len = rise2 - fall1;
  endtask

  initial begin
    int pulses, stops, gap, lo_len, hi_len, cnt;
    void'($urandom(32'd4242));

    // Reset with the data line already stuck (R9)
    sda_dev = 1'b1;
    step();
    step();
    chk("R9", "scl_pull in reset", scl_pull, 0);
    chk("R9", "sda_pull in reset", sda_pull, 0);
    chk("R9", "fault_disc in reset", fault_disc, 0);
    chk("R9", "recov_active in reset", recov_active, 0);
    rst_n = 1'b1;
    for (int i = 0; i < TO; i++) step();
    chk("R2", "fault_disc one edge before timeout", fault_disc, 0);
    step();
    chk("R9", "fault_disc after power-up timeout", fault_disc, 1);
    chk("R3", "recov_active at fault", recov_active, 1);
    watch(99, 1'b0, pulses, stops, gap, lo_len, hi_len);
    chk("R4", "pulses with bus never freed", pulses, NP);
    chk("R5", "stop conditions", stops, 1);
    chk("R3", "guard length", gap, GD);
    chk("R3", "clock low half", lo_len, HF);
    chk("R3", "clock high half", hi_len, HF);
    for (int i = 0; i < 20; i++) step();
    chk("R6", "still apart while stuck", fault_disc, 1);
    release_line(1'b0);
    step();
    chk("R6", "reconnect on stop edge", fault_disc, 0);

    // Short low spells alternate between lines: separate counters (R1)
    for (int i = 0; i < 5; i++) step();
    sda_dev = 1'b1;
    for (int i = 0; i < TO - 1; i++) step();
    sda_dev = 1'b0;
    scl_dev = 1'b1;
    for (int i = 0; i < TO - 1; i++) step();
    scl_dev = 1'b0;
    sda_dev = 1'b1;
    for (int i = 0; i < TO - 1; i++) step();
    sda_dev = 1'b0;
    for (int i = 0; i < 4; i++) step();
    chk("R1", "no fault from short spells", fault_disc, 0);
    chk("R1", "no sequence from short spells", recov_active, 0);

    // Clock line stuck, never freed, then released into idle (R1, R6)
    scl_dev = 1'b1;
    for (int i = 0; i < TO + 1; i++) step();
    chk("R1", "clock line timeout", fault_disc, 1);
    watch(99, 1'b1, pulses, stops, gap, lo_len, hi_len);
    chk("R4", "pulses with clock stuck", pulses, NP);
    chk("R5", "stop with clock stuck", stops, 1);
    for (int i = 0; i < 5; i++) step();
    chk("R6", "still apart with clock stuck", fault_disc, 1);
    release_line(1'b1);
    for (int i = 0; i < ID; i++) step();
    chk("R6", "idle run not yet complete", fault_disc, 1);
    step();
    chk("R6", "reconnect after idle run", fault_disc, 0);

    // Early end after pulse 5 (R4, R6)
    for (int i = 0; i < 5; i++) step();
    sda_dev = 1'b1;
    wait_active(500);
    watch(5, 1'b0, pulses, stops, gap, lo_len, hi_len);
    chk("R4", "early end after five pulses", pulses, 5);
    chk("R5", "stop after early end", stops, 1);
    step();
    chk("R6", "reconnect right after stop", fault_disc, 0);

    // Bus free at guard end: zero pulses, stop still sent (R4, R5)
    for (int i = 0; i < 5; i++) step();
    sda_dev = 1'b1;
    wait_active(500);
    watch(0, 1'b0, pulses, stops, gap, lo_len, hi_len);
    chk("R4", "zero pulses when freed in guard", pulses, 0);
    chk("R5", "stop sent with zero pulses", stops, 1);

    // Freed in the high half of the last allowed pulse (R4, R5)
    wait_fault(1'b0, 50);
    for (int i = 0; i < 5; i++) step();
    scl_dev = 1'b1;
    wait_active(500);
    watch(NP, 1'b1, pulses, stops, gap, lo_len, hi_len);
    chk("R4", "cap and recovery together", pulses, NP);
    chk("R5", "single stop at cap", stops, 1);
    step();
    chk("R6", "reconnect after cap", fault_disc, 0);

    // Enable low: fault flagged, no pulls (R8)
    for (int i = 0; i < 5; i++) step();
    en = 1'b0;
    sda_dev = 1'b1;
    cnt = 0;
    for (int i = 0; i < TO + GD + 40; i++) begin
      step();
      if (scl_pull || sda_pull || recov_active) cnt++;
    end
    chk("R8", "pull activity with enable low", cnt, 0);
    chk("R8", "fault still flagged with enable low", fault_disc, 1);

    // Enable rising edge forces reconnection and restarts the counters (R7)
    en = 1'b1;
    step();
    chk("R7", "fault cleared by enable edge", fault_disc, 0);
    for (int i = 0; i < TO; i++) step();
    chk("R7", "counter restarted from zero", fault_disc, 0);
    step();
    chk("R7", "counter still active after edge", fault_disc, 1);

    // Enable falls during the burst (R8)
    for (int i = 0; i < 200; i++) begin
      if (scl_pull) break;
      step();
    end
    en = 1'b0;
    step();
    chk("R8", "scl_pull after enable drop", scl_pull, 0);
    chk("R8", "recov_active after enable drop", recov_active, 0);
    chk("R8", "fault kept after enable drop", fault_disc, 1);
    sda_dev = 1'b0;
    step();
    en = 1'b1;
    step();
    chk("R7", "enable edge clears after abort", fault_disc, 0);

    // Random runs with gated ticks
    rnd_tick = 1'b1;
    for (int it = 0; it < 24; it++) begin
      int k;
      bit on_scl;
      k = int'($urandom % 20);
      on_scl = $urandom % 2;
      for (int i = 0; i < 4; i++) step();
      if (on_scl) scl_dev = 1'b1;
      else        sda_dev = 1'b1;
      wait_active(1000);
      watch(k, on_scl, pulses, stops, gap, lo_len, hi_len);
      chk("R4", $sformatf("random pulses k=%0d", k), pulses, exp_pulses(k));
      chk("R5", "random stop", stops, 1);
      if (k > NP) release_line(on_scl);
      wait_fault(1'b0, 200);
      chk("R6", "random reconnect", fault_disc, 0);
    end

    finish_run();
  end
endmodule